// File: doc/BRIEF.md
# Condition Register Lookup Logic Unit

This unit computes table-driven logic on a 32-bit condition register made of eight 4-bit fields. Each operation combines two or three source bits into an index. It uses that index to pick one bit from a lookup table, and the picked bit becomes a destination bit. The table comes either from an 8-bit immediate (three-input, "ternary" forms) or from the four bits of a condition register field (two-input, "binary" forms).

The field-wide forms process all four bit positions of a destination field in parallel. A per-bit write mask controls which of those positions are written. The single-bit forms address individual register bits with 5-bit selectors.

The caller presents the current register value, an opcode, three selectors, the immediate and the mask. One clock later the unit returns the updated register, a write enable and an illegal-instruction trap flag. All operands are taken from the register value as presented, so a destination that overlaps a source still sees the old bits.

Top module: `cr_lookup_unit`

## Requirements
- R1: A synchronous active-low reset drives `cr_o` to zero and clears `cr_we_o` and `trap_o` at the next rising edge, whatever the inputs are.
- R2: Outputs are registered: the result for inputs sampled at one rising edge appears after that edge and holds until the next.
- R3: Numbering is MSB-first. Register bit k is `cr_i[31-k]`. Field n holds bits 4n..4n+3, so field n is `cr_i[31-4n -: 4]`, and bit i of a field (i = 0 is leftmost) is bit 4n+i. Bit k of the immediate is `imm_i[7-k]`, and bit k of a table field is the field's bit k.
- R4: Opcode `op_i` = 1 (field ternary): for each bit i of destination field D = `dst_sel_i[2:0]`, idx = 4·D[i] + 2·A[i] + B[i] with A = field `src_a_sel_i[2:0]` and B = field `src_b_sel_i[2:0]`. The new bit is immediate bit idx.
- R5: Opcode 2 (field binary): idx = 2·D[i] + A[i], and the new bit is bit idx of table field B.
- R6: In both field forms, bit i of D is written only when `mask_i[3-i]` is 1. Other bits of D and all other fields keep their value.
- R7: Opcode 2 with `mask_i` = 0 raises `trap_o`, keeps `cr_we_o` low and returns `cr_o` equal to the sampled `cr_i`.
- R8: Opcode 1 with `mask_i` = 0 does not trap. It asserts `cr_we_o` and returns the register unchanged.
- R9: Opcode 3 (bit ternary): with T, P, Q = `dst_sel_i`, `src_a_sel_i`, `src_b_sel_i`, register bit T becomes immediate bit (4·bit T + 2·bit P + bit Q). No other bit changes.
- R10: Opcode 4 (bit binary): register bit T becomes bit (2·bit T + bit P) of table field `src_b_sel_i[2:0]`. No other bit changes.
- R11: Every index and table bit is read from the sampled `cr_i`, even when the destination overlaps a source or the table.
- R12: Opcode 0 and opcodes 5 to 7 leave the register unchanged, with `cr_we_o` and `trap_o` low. Every legal, non-trapping operation asserts `cr_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code (0 none, 1 field ternary, 2 field binary, 3 bit ternary, 4 bit binary) |
| cr_i | input | 32 | Current condition register |
| dst_sel_i | input | 5 | Destination bit, or destination field in bits [2:0] |
| src_a_sel_i | input | 5 | First source bit, or first source field in bits [2:0] |
| src_b_sel_i | input | 5 | Second source bit, or table / second source field in bits [2:0] |
| imm_i | input | 8 | Three-input lookup table |
| mask_i | input | 4 | Per-bit write mask for the field forms |
| cr_o | output | 32 | Updated condition register |
| cr_we_o | output | 1 | Result is to be written back |
| trap_o | output | 1 | Illegal-instruction trap |

## Verification
The bench aims at bit ordering. It uses a non-symmetric immediate and table, plus single-bit masks whose reversed reading would hit a different bit, so an LSB-first indexing bug changes the result. It sets an all-zero mask on both field forms: a design that trapped on the ternary form, or wrote back on the binary form, shows a wrong flag or a wrong register. A field-binary operation whose destination, source and table are all the same field returns each bit inverted only if the old value is used throughout; a design that fed updated bits back would produce another pattern. Undefined opcodes and a reset taken during an active operation confirm that nothing is written.

// File: rtl/crlu_pkg.sv
// Package for the condition register lookup unit.
// Holds the field geometry and the operation encoding shared by all modules.
// Assumes a field width of four, which matches a three-input 8-entry immediate
// table and a two-input 4-entry field table.
package crlu_pkg;
    localparam int FIELD_W = 4;
    localparam int IMM_W   = 8;

    typedef enum logic [2:0] {
        CRLU_NOP   = 3'd0,
        CRLU_FTERN = 3'd1,
        CRLU_FBIN  = 3'd2,
        CRLU_BTERN = 3'd3,
        CRLU_BBIN  = 3'd4
    } crlu_op_e;
endpackage

// File: rtl/crlu_field_calc.sv
// Field-wide lookup: computes a new destination field from the destination,
// a source field and a third field that serves as operand (immediate form) or
// as table (field-table form). Masked-off positions return the old bit.
// Assumes packed bit p of a field is field bit FIELD_W-1-p (MSB-first), so
// mask bit p pairs with packed position p.
module crlu_field_calc
    import crlu_pkg::*;
(
    input  logic [FIELD_W-1:0] d_i,
    input  logic [FIELD_W-1:0] a_i,
    input  logic [FIELD_W-1:0] t_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [FIELD_W-1:0] mask_i,
    input  logic               use_tbl_i,
    output logic [FIELD_W-1:0] res_o
);
    for (genvar p = 0; p < FIELD_W; p++) begin : g_pos
        logic [2:0] idx3;
        logic [1:0] idx2;
        logic       pick;
        // Index formation: destination bit is the most significant index bit.
        assign idx3 = {d_i[p], a_i[p], t_i[p]};
        assign idx2 = {d_i[p], a_i[p]};
        // Table bit k is stored at packed position (size-1-k), i.e. the inverted index.
        assign pick = use_tbl_i ? t_i[~idx2] : imm_i[~idx3];
        // Write only when the mask allows it.
        assign res_o[p] = mask_i[p] ? pick : d_i[p];
    end
endmodule

// File: rtl/crlu_bit_calc.sv
// Single-bit lookup: picks one entry of the immediate (three-input) or of a
// table field (two-input), indexed by the selected register bits.
// Assumes the table field is MSB-first like every other field.
module crlu_bit_calc
    import crlu_pkg::*;
(
    input  logic               bt_i,
    input  logic               ba_i,
    input  logic               bb_i,
    input  logic [FIELD_W-1:0] tbl_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic               use_tbl_i,
    output logic               res_o
);
    logic [2:0] idx3;
    logic [1:0] idx2;

    // Index formation with the destination bit as most significant.
    assign idx3 = {bt_i, ba_i, bb_i};
    assign idx2 = {bt_i, ba_i};
    // Entry selection from the chosen table.
    assign res_o = use_tbl_i ? tbl_i[~idx2] : imm_i[~idx3];
endmodule

// File: rtl/cr_lookup_unit.sv
// Condition register lookup logic unit (top).
// Decodes the operation, gathers operands from the presented register value,
// runs the field or bit lookup and registers the merged result, the write
// enable and the trap flag. All reads use cr_i as sampled; nothing is forwarded.
// Assumes NUM_FIELDS is a power of two so MSB-first numbering reduces to
// bitwise inversion of the selector.
module cr_lookup_unit
    import crlu_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    localparam int CR_W   = NUM_FIELDS * FIELD_W,
    localparam int FSEL_W = $clog2(NUM_FIELDS),
    localparam int BSEL_W = $clog2(CR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [CR_W-1:0]   cr_i,
    input  logic [BSEL_W-1:0] dst_sel_i,
    input  logic [BSEL_W-1:0] src_a_sel_i,
    input  logic [BSEL_W-1:0] src_b_sel_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [FIELD_W-1:0] mask_i,
    output logic [CR_W-1:0]   cr_o,
    output logic              cr_we_o,
    output logic              trap_o
);
    crlu_op_e op;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] crf;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] nxt_field;
    logic [CR_W-1:0]    nxt_bit;
    logic [CR_W-1:0]    cr_next;
    logic               we_next;
    logic               trap_next;
    logic [FSEL_W-1:0]  dst_f, a_f, b_f;
    logic [FIELD_W-1:0] fres;
    logic               bres;

    assign op    = crlu_op_e'(op_i);
    assign crf   = cr_i;
    assign dst_f = dst_sel_i[FSEL_W-1:0];
    assign a_f   = src_a_sel_i[FSEL_W-1:0];
    assign b_f   = src_b_sel_i[FSEL_W-1:0];

    crlu_field_calc u_field (
        .d_i       (crf[~dst_f]),
        .a_i       (crf[~a_f]),
        .t_i       (crf[~b_f]),
        .imm_i     (imm_i),
        .mask_i    (mask_i),
        .use_tbl_i (op == CRLU_FBIN),
        .res_o     (fres)
    );

    crlu_bit_calc u_bit (
        .bt_i      (cr_i[~dst_sel_i]),
        .ba_i      (cr_i[~src_a_sel_i]),
        .bb_i      (cr_i[~src_b_sel_i]),
        .tbl_i     (crf[~b_f]),
        .imm_i     (imm_i),
        .use_tbl_i (op == CRLU_BBIN),
        .res_o     (bres)
    );

    // Merge lookup results into the register image and decide write/trap.
    always_comb begin
        nxt_field        = crf;
        nxt_field[~dst_f] = fres;
        nxt_bit          = cr_i;
        nxt_bit[~dst_sel_i] = bres;
        cr_next   = cr_i;
        we_next   = 1'b0;
        trap_next = 1'b0;
        case (op)
            CRLU_FTERN: begin
                cr_next = nxt_field;
                we_next = 1'b1;
            end
            CRLU_FBIN: begin
                if (mask_i == '0) begin
                    trap_next = 1'b1;
                end else begin
                    cr_next = nxt_field;
                    we_next = 1'b1;
                end
            end
            CRLU_BTERN, CRLU_BBIN: begin
                cr_next = nxt_bit;
                we_next = 1'b1;
            end
            default: ;
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_o    <= '0;
            cr_we_o <= 1'b0;
            trap_o  <= 1'b0;
        end else begin
            cr_o    <= cr_next;
            cr_we_o <= we_next;
            trap_o  <= trap_next;
        end
    end

    // ---------------- assertions ----------------
    // Footprint of bits an operation may touch, built from shifts rather than lookup.
    logic [CR_W-1:0] sva_foot;
    always_comb begin
        if (op == CRLU_FTERN || op == CRLU_FBIN)
            sva_foot = {mask_i, {(CR_W-FIELD_W){1'b0}}} >> (FIELD_W * int'(dst_f));
        else
            sva_foot = {1'b1, {(CR_W-1){1'b0}}} >> dst_sel_i;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst_n) == 1'b0 |-> (cr_o == '0 && !cr_we_o && !trap_o));

    assert_write_in_footprint_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && cr_we_o |-> ((cr_o ^ $past(cr_i)) & ~$past(sva_foot)) == '0);

    assert_trap_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && trap_o |-> ($past(op) == CRLU_FBIN && $past(mask_i) == '0));

    assert_trap_holds_cr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && trap_o |-> (!cr_we_o && cr_o == $past(cr_i)));

    assert_single_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(op) == CRLU_BTERN || $past(op) == CRLU_BBIN)
        |-> ($countones(cr_o ^ $past(cr_i)) <= 1 && cr_we_o));

    assert_nop_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(op_i) == 3'd0 || $past(op_i) > 3'd4)
        |-> (!cr_we_o && !trap_o && cr_o == $past(cr_i)));
endmodule

// File: tb/cr_lookup_unit_tb.sv
// Self-checking bench: vector table walk, model-checked sweep, reset cases.
module cr_lookup_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op;
    logic [31:0] cr_in;
    logic [4:0]  dsel, asel, bsel;
    logic [7:0]  imm;
    logic [3:0]  mask;
    logic [31:0] cr_out;
    logic        we, trap;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    cr_lookup_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .cr_i(cr_in),
        .dst_sel_i(dsel), .src_a_sel_i(asel), .src_b_sel_i(bsel),
        .imm_i(imm), .mask_i(mask),
        .cr_o(cr_out), .cr_we_o(we), .trap_o(trap)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [4:0]  d, a, b;
        logic [7:0]  imm;
        logic [3:0]  mask;
        logic [31:0] cr;
        logic [31:0] exp_cr;
        logic        exp_we, exp_trap;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 5'd0, 5'd1, 5'd2,  8'h17, 4'hF, 32'hCA600000, 32'hEA600000, 1'b1, 1'b0}, // R4 majority
        '{3'd1, 5'd0, 5'd1, 5'd2,  8'h17, 4'h2, 32'hCA600000, 32'hEA600000, 1'b1, 1'b0}, // R6 mask bit 2
        '{3'd1, 5'd0, 5'd1, 5'd2,  8'h17, 4'h1, 32'hCA600000, 32'hCA600000, 1'b1, 1'b0}, // R6 mask bit 3
        '{3'd1, 5'd0, 5'd1, 5'd2,  8'h17, 4'h0, 32'hCA600000, 32'hCA600000, 1'b1, 1'b0}, // R8
        '{3'd2, 5'd3, 5'd4, 5'd5,  8'h00, 4'hF, 32'h00053600, 32'h00063600, 1'b1, 1'b0}, // R5 xor table
        '{3'd2, 5'd3, 5'd4, 5'd5,  8'h00, 4'h0, 32'h00053600, 32'h00053600, 1'b0, 1'b1}, // R7
        '{3'd3, 5'd2, 5'd9, 5'd30, 8'h10, 4'h0, 32'h00400002, 32'h20400002, 1'b1, 1'b0}, // R9
        '{3'd4, 5'd7, 5'd0, 5'd6,  8'h00, 4'h0, 32'h010000D0, 32'h000000D0, 1'b1, 1'b0}, // R10
        '{3'd2, 5'd0, 5'd0, 5'd0,  8'h00, 4'hF, 32'hA0000000, 32'h50000000, 1'b1, 1'b0}, // R11 overlap
        '{3'd0, 5'd1, 5'd2, 5'd3,  8'hFF, 4'hF, 32'h12345678, 32'h12345678, 1'b0, 1'b0}, // R12 nop
        '{3'd7, 5'd1, 5'd2, 5'd3,  8'hFF, 4'hF, 32'h12345678, 32'h12345678, 1'b0, 1'b0}  // R12 undefined
    };

    // Reference written from the requirements with MSB-first numbering.
    function automatic logic [33:0] model(input logic [2:0] o, input logic [31:0] c,
                                          input int d, input int a, input int b,
                                          input logic [7:0] im, input logic [3:0] mk);
        logic [31:0] r = c;
        int df = d % 8, af = a % 8, bf = b % 8;
        int idx;
        if (o == 3'd1 || o == 3'd2) begin
            if (o == 3'd2 && mk == 4'h0) return {c, 1'b0, 1'b1};
            for (int i = 0; i < 4; i++) begin
                if (o == 3'd1)
                    idx = 4*c[31-(4*df+i)] + 2*c[31-(4*af+i)] + c[31-(4*bf+i)];
                else
                    idx = 2*c[31-(4*df+i)] + c[31-(4*af+i)];
                if (mk[3-i])
                    r[31-(4*df+i)] = (o == 3'd1) ? im[7-idx] : c[31-(4*bf+idx)];
            end
            return {r, 1'b1, 1'b0};
        end else if (o == 3'd3) begin
            idx = 4*c[31-d] + 2*c[31-a] + c[31-b];
            r[31-d] = im[7-idx];
            return {r, 1'b1, 1'b0};
        end else if (o == 3'd4) begin
            idx = 2*c[31-d] + c[31-a];
            r[31-d] = c[31-(4*bf+idx)];
            return {r, 1'b1, 1'b0};
        end
        return {c, 1'b0, 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] ecr, input logic ewe, input logic etr);
        checks++;
        if (cr_out !== ecr || we !== ewe || trap !== etr) begin
            failures++;
            $display("FAIL %s: cr=%h we=%b trap=%b expected cr=%h we=%b trap=%b",
                     req, cr_out, we, trap, ecr, ewe, etr);
        end
    endtask

    task automatic drive(input logic [2:0] o, input logic [31:0] c, input logic [4:0] d,
                         input logic [4:0] a, input logic [4:0] b, input logic [7:0] im,
                         input logic [3:0] mk);
        @(negedge clk);
        op = o; cr_in = c; dsel = d; asel = a; bsel = b; imm = im; mask = mk;
        @(negedge clk);  // one rising edge in between registers the result (R2)
    endtask

    initial begin
        rst_n = 1'b0; op = 3'd1; cr_in = 32'hFFFF_FFFF; dsel = '0; asel = '0; bsel = '0;
        imm = 8'hFF; mask = 4'hF;
        repeat (3) @(negedge clk);
        check("R1 reset state", 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        foreach (VECS[n]) begin
            drive(VECS[n].op, VECS[n].cr, VECS[n].d, VECS[n].a, VECS[n].b, VECS[n].imm, VECS[n].mask);
            check($sformatf("R2/R3 vector %0d", n), VECS[n].exp_cr, VECS[n].exp_we, VECS[n].exp_trap);
        end

        // Sweep of all opcodes against the requirement model (R4, R5, R9, R10, R11).
        for (int n = 0; n < 80; n++) begin
            logic [2:0] o = 3'(n % 8);
            logic [31:0] c = $urandom;
            logic [4:0] d = 5'($urandom), a = 5'($urandom), b = 5'($urandom);
            logic [7:0] im = 8'($urandom);
            logic [3:0] mk = 4'($urandom);
            logic [33:0] e = model(o, c, int'(d), int'(a), int'(b), im, mk);
            drive(o, c, d, a, b, im, mk);
            check("R4/R5/R9/R10 sweep", e[33:2], e[1], e[0]);
        end

        // Output holds when inputs change between edges (R2).
        drive(3'd3, 32'h0, 5'd31, 5'd0, 5'd0, 8'hFF, 4'h0);
        #1 cr_in = 32'h5555_5555;
        #1 check("R2 hold between edges", 32'h0000_0001, 1'b1, 1'b0);

        // Reset taken while an operation is presented (R1).
        @(negedge clk);
        op = 3'd1; cr_in = 32'hCA600000; dsel = 5'd0; asel = 5'd1; bsel = 5'd2; imm = 8'h17; mask = 4'hF;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset during operation", 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Trap after a write: trap must not carry over a write enable (R7).
        drive(3'd2, 32'hFFFF0000, 5'd7, 5'd6, 5'd5, 8'h00, 4'h0);
        check("R7 trap keeps cr", 32'hFFFF0000, 1'b0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule